// File: doc/BRIEF.md
# Single-History Delay Channel

This block is a clocked, discrete-time model of a binary delay channel in which time advances one unit per clock cycle. It watches a 1-bit input for value changes and schedules a matching output change some cycles later. The delay of each scheduled change is a function of the signed distance between the input change and a reference time. In forgetful mode the reference is the most recent event still present in the output history. In non-forgetful mode it is the most recent candidate time computed, whether or not that candidate survived. A scheduled change that would fall at or before its reference is not queued. Instead it cancels the newest pending change, so that short pulses vanish in pairs.

Three delay shapes can be selected at run time: a fixed delay, an inertial shape with a threshold, and a saturating ramp held in a small table that the block computes itself. Pending changes wait in a small time-ordered queue. When the free-running cycle counter reaches the time of the oldest entry, that entry drives the output. A one-cycle flag reports a change that was lost because the queue was full.

Top module: `shist_chan`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `dout` equals `init_val`, nothing is pending and `q_overflow` is 0. The value `init_val` acts as a history event placed infinitely far in the past.
- R2: An input change sampled at a clock edge, whose new value equals the value of the newest history event, has no effect. A pending change is the newest history event if one exists. Otherwise the newest event is the last emitted output, or `init_val`.
- R3: For any other input change sampled at cycle t, the design computes T = t − ref and cand = t + d(T). When there is no reference, or the reference is more than 1024 cycles old, d(∞) is used. The output takes the new value at the clock edge that comes d clock edges after the edge that sampled the input change.
- R4: If cand is not strictly later than ref, the newest pending change is removed and the new change is discarded. If nothing is pending, only the new change is discarded.
- R5: With `nonforget`=0, ref is the time of the newest history event. With `nonforget`=1, ref is the candidate time computed for the previous accepted input change, even when that candidate was cancelled.
- R6: `dout` changes only at an edge where a queued change falls due.
- R7: With `shape`=0 (code 3 acts the same), d = `const_dly`, which must be 1 or more. A pulse of any length is reproduced with that delay, and the result is the same in both modes.
- R8: With `shape`=1, d = `inr_dly` when T > −`inr_back`, and d = `inr_back` otherwise. The setting requires `inr_back` < `inr_dly`. An isolated input pulse no longer than `inr_dly`−`inr_back` cycles is suppressed. A longer pulse passes with delay `inr_dly`.
- R9: If a change has to be queued while the queue is full (QD entries, none falling due that cycle), it is dropped, and `q_overflow` is 1 for the following cycle. The queue never holds more than QD entries.
- R10: With `shape`=2, the table index is 0 for T < 0, min(T/4, 7) for T ≥ 0, and 7 for T = ∞. Entry k equals 1 + 16 − (16 >> k), which gives the values 1, 9, 13, 15, 16, 17, 17, 17.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cycle is one time unit |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | 1 | Channel input signal |
| init_val | input | 1 | Output value and virtual first event while in reset |
| nonforget | input | 1 | 1 selects non-forgetful reference tracking |
| shape | input | 2 | Delay shape: 0 fixed, 1 inertial, 2 table, 3 fixed |
| const_dly | input | DW | Delay of the fixed shape |
| inr_dly | input | DW | Long delay of the inertial shape |
| inr_back | input | DW | Negated threshold of the inertial shape and its short delay |
| dout | output | 1 | Delayed channel output |
| q_overflow | output | 1 | One-cycle pulse when a change was dropped on a full queue |

## Verification
The bench targets the exact pulse-length boundaries at which the inertial and table shapes begin to pass a pulse. A design that compares with ≥ instead of > either lets through a pulse that should vanish or swallows one that should pass. A short pulse followed two cycles later by a long one tells the two modes apart. Measuring from a cancelled candidate moves the second rising edge from 24 cycles to 8, so a design that mixes up the references shows the wrong rise time. The bench also starts from an initial value of 1 with the input already high, so that a design which schedules a change of equal value would cancel the later falling edge and hold the output high. Finally, a burst of input changes must raise the overflow pulse on exactly one cycle and must leave the output at the value it reached before the dropped change.

// File: rtl/shc_pkg.sv
package shc_pkg;

  typedef enum logic [1:0] {
    SHP_CONST = 2'd0,
    SHP_INERT = 2'd1,
    SHP_TABLE = 2'd2,
    SHP_RSVD  = 2'd3
  } shape_e;

  // Saturating ramp standing in for an exponential approach: nondecreasing in k.
  function automatic int table_entry(input int k, input int top);
    return 1 + top - (top >>> k);
  endfunction

endpackage

// File: rtl/shc_delay_fn.sv
module shc_delay_fn #(
  parameter int TW        = 12,
  parameter int DW        = 8,
  parameter int LUT_N     = 8,
  parameter int LUT_SHIFT = 2,
  parameter int LUT_MAX   = 16
) (
  input  logic [1:0]           shape,
  input  logic                 span_inf,
  input  logic signed [TW-1:0] span,
  input  logic [DW-1:0]        const_dly,
  input  logic [DW-1:0]        inr_dly,
  input  logic [DW-1:0]        inr_back,
  output logic signed [TW-1:0] dly
);
  localparam int IW = (LUT_N > 1) ? $clog2(LUT_N) : 1;

  logic [TW-1:0] tbl [LUT_N];
  for (genvar k = 0; k < LUT_N; k++) begin : g_tbl
    assign tbl[k] = TW'(shc_pkg::table_entry(k, LUT_MAX));
  end

  function automatic logic [IW-1:0] tbl_index(input logic inf, input logic signed [TW-1:0] s);
    logic signed [TW-1:0] q;
    q = s >>> LUT_SHIFT;
    if (inf)                                  return IW'(LUT_N - 1);
    else if (s < 0)                           return '0;
    else if (q >= $signed(TW'(LUT_N)))        return IW'(LUT_N - 1);
    else                                      return q[IW-1:0];
  endfunction

  logic signed [TW-1:0] back_s;
  logic [IW-1:0]        idx;

  always_comb begin
    back_s = $signed(TW'(inr_back));
    idx    = tbl_index(span_inf, span);
    case (shape)
      shc_pkg::SHP_INERT: dly = (span_inf || (span > -back_s)) ? $signed(TW'(inr_dly)) : back_s;
      shc_pkg::SHP_TABLE: dly = $signed(tbl[idx]);
      default:            dly = $signed(TW'(const_dly));
    endcase
  end
endmodule

// File: rtl/shc_evq.sv
module shc_evq #(
  parameter int TW = 12,
  parameter int QD = 4,
  localparam int PW = $clog2(QD),
  localparam int CW = PW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [TW-1:0] push_time,
  input  logic          push_val,
  input  logic          drop_tail,
  input  logic          pop,
  output logic [TW-1:0] head_time,
  output logic          head_val,
  output logic [TW-1:0] tail_time,
  output logic          tail_val,
  output logic [CW-1:0] cnt
);
  logic [TW-1:0] tm [QD];
  logic [QD-1:0] vl;
  logic [PW-1:0] hd;
  logic [PW-1:0] wr_idx;
  logic [PW-1:0] tl_idx;

  assign wr_idx    = hd + PW'(cnt);
  assign tl_idx    = hd + PW'(cnt - CW'(1));
  assign head_time = tm[hd];
  assign head_val  = vl[hd];
  assign tail_time = tm[tl_idx];
  assign tail_val  = vl[tl_idx];

  always_ff @(posedge clk) begin
    if (push) begin
      tm[wr_idx] <= push_time;
      vl[wr_idx] <= push_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hd  <= '0;
      cnt <= '0;
    end else begin
      hd  <= hd + PW'(pop);
      cnt <= cnt + CW'(push) - CW'(pop) - CW'(drop_tail);
    end
  end
endmodule

// File: rtl/shist_chan.sv
module shist_chan #(
  parameter int TW        = 12,
  parameter int DW        = 8,
  parameter int QD        = 4,
  parameter int LUT_N     = 8,
  parameter int LUT_SHIFT = 2,
  parameter int LUT_MAX   = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          din,
  input  logic          init_val,
  input  logic          nonforget,
  input  logic [1:0]    shape,
  input  logic [DW-1:0] const_dly,
  input  logic [DW-1:0] inr_dly,
  input  logic [DW-1:0] inr_back,
  output logic          dout,
  output logic          q_overflow
);
  localparam int CW = $clog2(QD) + 1;
  localparam logic [TW-1:0] QUARTER = TW'(1) << (TW - 2);

  logic [TW-1:0] now;
  logic          din_q;
  logic [TW-1:0] lo_time;
  logic          lo_valid;
  logic [TW-1:0] r_time;
  logic          r_valid;

  logic [TW-1:0] head_time, tail_time;
  logic          head_val, tail_val;
  logic [CW-1:0] q_cnt, cnt_eff;

  // named internal events
  logic          pop_fire, in_evt, act, later;
  logic          push_fire, del_fire, drop_fire;
  logic [TW-1:0] last_time, ref_time, cand;
  logic          last_val, last_valid, ref_inf;
  logic signed [TW-1:0] span, dly;
  logic          lo_stale, r_stale;

  function automatic logic is_after(input logic [TW-1:0] a, input logic [TW-1:0] b);
    return $signed(a - b) > 0;
  endfunction

  always_comb begin
    pop_fire = (q_cnt != '0) && (head_time == now);
    cnt_eff  = q_cnt - CW'(pop_fire);
    if (cnt_eff != '0) begin
      last_time = tail_time; last_val = tail_val; last_valid = 1'b1;
    end else if (pop_fire) begin
      last_time = head_time; last_val = head_val; last_valid = 1'b1;
    end else begin
      last_time = lo_time;   last_val = dout;     last_valid = lo_valid;
    end
    in_evt   = din != din_q;
    act      = in_evt && (din != last_val);
    ref_time = nonforget ? r_time : last_time;
    ref_inf  = nonforget ? !r_valid : !last_valid;
    span     = $signed(now - ref_time);
    cand     = now + dly;
    later    = ref_inf || is_after(cand, ref_time);
    push_fire = act && later && (cnt_eff != CW'(QD));
    drop_fire = act && later && (cnt_eff == CW'(QD));
    del_fire  = act && !later && (cnt_eff != '0);
    lo_stale  = lo_valid && ((now - lo_time) >= QUARTER);
    r_stale   = r_valid && ($signed(now - r_time) >= $signed(QUARTER));
  end

  shc_delay_fn #(
    .TW(TW), .DW(DW), .LUT_N(LUT_N), .LUT_SHIFT(LUT_SHIFT), .LUT_MAX(LUT_MAX)
  ) dfn_i (
    .shape(shape), .span_inf(ref_inf), .span(span),
    .const_dly(const_dly), .inr_dly(inr_dly), .inr_back(inr_back), .dly(dly)
  );

  shc_evq #(.TW(TW), .QD(QD)) q_i (
    .clk(clk), .rst_n(rst_n),
    .push(push_fire), .push_time(cand), .push_val(din),
    .drop_tail(del_fire), .pop(pop_fire),
    .head_time(head_time), .head_val(head_val),
    .tail_time(tail_time), .tail_val(tail_val), .cnt(q_cnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      now        <= '0;
      din_q      <= 1'b0;
      dout       <= init_val;
      lo_time    <= '0;
      lo_valid   <= 1'b0;
      r_time     <= '0;
      r_valid    <= 1'b0;
      q_overflow <= 1'b0;
    end else begin
      now        <= now + TW'(1);
      din_q      <= din;
      q_overflow <= drop_fire;
      if (pop_fire) begin
        dout     <= head_val;
        lo_time  <= head_time;
        lo_valid <= 1'b1;
      end else if (lo_stale) begin
        lo_valid <= 1'b0;
      end
      if (act) begin
        r_time  <= cand;
        r_valid <= 1'b1;
      end else if (r_stale) begin
        r_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/shc_chk.sv
module shc_chk #(
  parameter int QD = 4,
  localparam int CW = $clog2(QD) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          init_val,
  input logic          dout,
  input logic          pop_fire,
  input logic          q_overflow,
  input logic [CW-1:0] q_cnt
);
  // R1: output sits at the initial value coming out of reset
  a_r1_reset_value: assert property (@(posedge clk) !rst_n |=> (dout == init_val));

  // R6: output moves only when a queued change falls due
  a_r6_quiet_output: assert property (@(posedge clk) disable iff (!rst_n)
    !pop_fire |=> $stable(dout));

  // R9: a drop is reported only after the queue was full
  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    q_overflow |-> ($past(q_cnt) == CW'(QD)));

  // R9: occupancy bound
  a_r9_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    q_cnt <= CW'(QD));
endmodule

bind shist_chan shc_chk #(.QD(QD)) chk_i (
  .clk(clk), .rst_n(rst_n), .init_val(init_val), .dout(dout),
  .pop_fire(pop_fire), .q_overflow(q_overflow), .q_cnt(q_cnt)
);

// File: tb/shist_chan_tb_top.sv
module shist_chan_tb_top;
  localparam int CLK_P = 10;
  localparam int WIN   = 60;
  localparam int NV    = 12;
  // shape, nonforget, pulse length, expected rise sample (0 = none), expected width
  localparam int VEC [NV][5] = '{
    '{0, 0,  1,  6,  1},
    '{0, 1,  1,  6,  1},
    '{0, 0,  3,  6,  3},
    '{0, 1,  3,  6,  3},
    '{1, 0,  4,  0,  0},
    '{1, 1,  4,  0,  0},
    '{1, 0,  5,  7,  5},
    '{1, 1,  5,  7,  5},
    '{2, 0, 16,  0,  0},
    '{2, 0, 17, 18,  1},
    '{2, 1, 20, 18,  4},
    '{2, 0, 21, 18, 13}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       din = 1'b0;
  logic       init_val = 1'b0;
  logic       nonforget = 1'b0;
  logic [1:0] shape = 2'd0;
  logic [7:0] const_dly = 8'd5;
  logic [7:0] inr_dly = 8'd6;
  logic [7:0] inr_back = 8'd2;
  logic       dout, q_overflow;

  int nchk = 0;
  int nerr = 0;

  always #(CLK_P/2) clk = ~clk;

  shist_chan dut_i (
    .clk(clk), .rst_n(rst_n), .din(din), .init_val(init_val), .nonforget(nonforget),
    .shape(shape), .const_dly(const_dly), .inr_dly(inr_dly), .inr_back(inr_back),
    .dout(dout), .q_overflow(q_overflow)
  );

  task automatic check_eq(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic iv);
    @(negedge clk);
    rst_n = 1'b0;
    init_val = iv;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run_pulse(input int len, output int rise, output int width);
    rise = 0;
    width = 0;
    @(negedge clk);
    din = 1'b1;
    for (int k = 1; k <= WIN; k++) begin
      @(negedge clk);
      if (dout) begin
        if (rise == 0) rise = k;
        width++;
      end
      if (k == len) din = 1'b0;
    end
  endtask

  task automatic double_pulse(input logic nf, input int exp_rise);
    int rise;
    rise = 0;
    shape = 2'd2;
    nonforget = nf;
    @(negedge clk);
    din = 1'b1;
    for (int k = 1; k <= 70; k++) begin
      @(negedge clk);
      if (dout && rise == 0) rise = k;
      if (k == 5)  din = 1'b0;
      if (k == 7)  din = 1'b1;
      if (k == 37) din = 1'b0;
    end
    repeat (40) @(negedge clk);
    check_eq($sformatf("R4/R5 double pulse rise nonforget=%0d", nf), rise, exp_rise);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin : main
    int rise, width;
    string tg;
    do_reset(1'b0);
    @(negedge clk);
    check_eq("R1 dout after reset", dout, 0);
    check_eq("R1 overflow after reset", q_overflow, 0);
    repeat (20) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      shape = 2'(VEC[i][0]);
      nonforget = VEC[i][1][0];
      tg = (VEC[i][0] == 0) ? "R7" : (VEC[i][0] == 1) ? "R8" : "R10";
      run_pulse(VEC[i][2], rise, width);
      check_eq($sformatf("%s/R3 rise vec%0d len=%0d", tg, i, VEC[i][2]), rise, VEC[i][3]);
      check_eq($sformatf("%s width vec%0d len=%0d", tg, i, VEC[i][2]), width, VEC[i][4]);
    end

    double_pulse(1'b0, 25);
    double_pulse(1'b1, 9);

    // R9: burst of six changes into a four-entry queue, fixed delay 5
    shape = 2'd0;
    nonforget = 1'b0;
    for (int k = 0; k <= 5; k++) begin
      @(negedge clk);
      if (k == 4) check_eq("R9 no overflow before full", q_overflow, 0);
      if (k == 5) check_eq("R9 overflow pulse", q_overflow, 1);
      din = ~din;
    end
    @(negedge clk);
    check_eq("R9 overflow is one cycle", q_overflow, 0);
    repeat (20) @(negedge clk);
    check_eq("R9/R2 final dout after drop", dout, 0);

    // R2: initial value 1 with input already high; later fall uses d(inf)
    shape = 2'd1;
    din = 1'b1;
    do_reset(1'b1);
    @(negedge clk);
    check_eq("R1 dout after reset init1", dout, 1);
    repeat (3) @(negedge clk);
    check_eq("R2 equal value change ignored", dout, 1);
    din = 1'b0;
    for (int k = 1; k <= 7; k++) begin
      @(negedge clk);
      if (k == 6) check_eq("R2/R8 fall not yet due", dout, 1);
      if (k == 7) check_eq("R2/R8 fall after inr_dly", dout, 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule